// File: doc/BRIEF.md
# 16-bit Rotate and Shift Unit

This block performs one of five single-operand bit-movement operations on a 16-bit value: rotate left, rotate right, logical shift left, logical shift right and arithmetic shift right. Each cycle the caller presents an operand, an 8-bit count, a 3-bit operation code and a valid strobe. One clock later the unit returns the moved value, five flag values (carry, overflow, sign, zero, parity) and a mask that tells the caller which of those flags it should write into its status word.

The count is interpreted differently per family. Rotates move the data by the low four count bits only, but a count whose low four bits are zero and whose bit 4 is set still refreshes carry and overflow from the unchanged operand. Shifts use the low five count bits, so counts larger than the operand width are legal: a left shift past 16 places gives zero with clean carry and overflow, and a right shift saturates to zero or to the sign.

Top module: `rotshift16`

## Requirements
- R1: While rstN is low, outValid, outResult, outFlagMask and all five flag outputs are 0.
- R2: An item accepted with inValid high at a rising edge appears with outValid high after that same edge; a cycle with inValid low gives outValid low after the edge.
- R3: inOp codes are 0 rotate left, 1 rotate right, 2 shift left, 3 logical shift right, 4 arithmetic shift right; codes 5 to 7 return the operand unchanged with outFlagMask 0.
- R4: Rotate left moves the data left by inCount[3:0]; carry is result bit 0, overflow is result bit 0 XOR result bit 15; outFlagMask is 5'b00011 (bit 0 carry, bit 1 overflow, bit 2 sign, bit 3 zero, bit 4 parity).
- R5: Rotate right moves the data right by inCount[3:0]; carry is result bit 15, overflow is result bit 15 XOR result bit 14; outFlagMask is 5'b00011.
- R6: For either rotate, inCount[3:0] of zero with inCount[4] set returns the operand with carry and overflow recomputed from it and mask 5'b00011; inCount[4:0] of zero returns the operand with mask 0; inCount[7:5] never matter.
- R7: For the three shifts the count is inCount[4:0]; a value of zero returns the operand with outFlagMask 0.
- R8: Shift left by n in 1..16 gives carry equal to operand bit 16−n and overflow equal to carry XOR result bit 15; for n above 16 result, carry and overflow are all 0.
- R9: Logical shift right by n gives carry equal to operand bit n−1 (0 when n exceeds 16) and overflow equal to result bit 15 XOR result bit 14; the result is 0 for n of 16 or more.
- R10: Arithmetic shift right fills with operand bit 15; carry is bit n−1 of the operand sign-extended to 32 bits; overflow is always 0.
- R11: A nonzero shift sets outFlagMask to 5'b11111, sign to result bit 15, zero to 1 when the result is 0, and parity to 1 when result bits 7:0 hold an even number of ones.
- R12: Every flag output whose outFlagMask bit is 0 reads 0 while outValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation request strobe |
| inOp | input | 3 | Operation code |
| inCount | input | 8 | Shift or rotate count |
| inOperand | input | 16 | Data to move |
| outValid | output | 1 | Result strobe, one cycle after the request |
| outResult | output | 16 | Moved data |
| outFlagMask | output | 5 | Flags to be written: bit 0 carry, 1 overflow, 2 sign, 3 zero, 4 parity |
| outCarry | output | 1 | Carry value |
| outOverflow | output | 1 | Overflow value |
| outSign | output | 1 | Sign value |
| outZero | output | 1 | Zero value |
| outParity | output | 1 | Parity value |

## Verification
Every result, mask and flag is registered once, so all of them are due right after the rising edge that accepted the request, and an idle cycle is due as outValid low after its edge. The driver changes inputs on falling edges and queues one expectation per cycle, idle cycles included; the monitor pops one entry 2 ns after every rising edge, so each comparison lands in the cycle the item is due and a late, early or missing strobe shows up as a mismatch. Expected values come from a bit-at-a-time model of each operation, with directed counts at 0, 1, 15, 16, 17 and 31, rotate counts with only bit 4 or only bits 7:5 set, and unused operation codes, followed by a long pseudo-random stream.

// File: rtl/rotshift16_pkg.sv
`timescale 1ns/1ps
package rotshift16_pkg;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int OP_W   = 3;
  localparam int ROT_W  = $clog2(DATA_W);
  localparam int SH_W   = ROT_W + 1;
  localparam int FLAG_N = 5;

  localparam int FL_CARRY = 0;
  localparam int FL_OVER  = 1;
  localparam int FL_SIGN  = 2;
  localparam int FL_ZERO  = 3;
  localparam int FL_PAR   = 4;

  localparam logic [OP_W-1:0] OP_ROL = 3'd0;
  localparam logic [OP_W-1:0] OP_ROR = 3'd1;
  localparam logic [OP_W-1:0] OP_SHL = 3'd2;
  localparam logic [OP_W-1:0] OP_SHR = 3'd3;
  localparam logic [OP_W-1:0] OP_SAR = 3'd4;

  localparam logic [FLAG_N-1:0] MASK_ROT   = FLAG_N'((1 << FL_CARRY) | (1 << FL_OVER));
  localparam logic [FLAG_N-1:0] MASK_SHIFT = '1;

  typedef struct packed {
    logic              selRol;
    logic              selRor;
    logic              selShl;
    logic              selShr;
    logic              selSar;
    logic [SH_W-1:0]   amount;
    logic [FLAG_N-1:0] flagMask;
  } strobes_t;

  typedef struct packed {
    logic [DATA_W-1:0] result;
    logic              carry;
    logic              over;
    logic              sign;
    logic              zero;
    logic              parity;
  } dpOut_t;
endpackage

// File: rtl/rotshift16_ctrl.sv
`timescale 1ns/1ps
module rotshift16_ctrl
  import rotshift16_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic [CNT_W-1:0] count,
  output strobes_t         strobes
);
  logic anyCount;
  logic isRot;
  logic isShift;

  always_comb begin
    anyCount = |count[SH_W-1:0];
    isRot    = (op == OP_ROL) || (op == OP_ROR);
    isShift  = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);

    strobes        = '0;
    strobes.amount = count[SH_W-1:0];
    strobes.selRol = (op == OP_ROL);
    strobes.selRor = (op == OP_ROR);
    strobes.selShl = (op == OP_SHL);
    strobes.selShr = (op == OP_SHR);
    strobes.selSar = (op == OP_SAR);

    if (anyCount && isRot) begin
      strobes.flagMask = MASK_ROT;
    end else if (anyCount && isShift) begin
      strobes.flagMask = MASK_SHIFT;
    end else begin
      strobes.flagMask = '0;
    end
  end
endmodule

// File: rtl/rotshift16_dp.sv
`timescale 1ns/1ps
module rotshift16_dp
  import rotshift16_pkg::*;
(
  input  strobes_t          st,
  input  logic [DATA_W-1:0] opnd,
  output dpOut_t            dpo
);
  localparam int EXT_W = 2 * DATA_W;

  logic [ROT_W-1:0]        rotAmt;
  logic [EXT_W-1:0]        rolExt;
  logic [EXT_W-1:0]        rorExt;
  logic [EXT_W-1:0]        shlExt;
  logic [EXT_W-1:0]        shrExt;
  logic signed [EXT_W-1:0] sarIn;
  logic signed [EXT_W-1:0] sarExt;
  logic [DATA_W-1:0]       res;

  always_comb begin
    rotAmt = st.amount[ROT_W-1:0];
    rolExt = {opnd, opnd} << rotAmt;
    rorExt = {opnd, opnd} >> rotAmt;
    shlExt = {{DATA_W{1'b0}}, opnd} << st.amount;
    shrExt = {opnd, {DATA_W{1'b0}}} >> st.amount;
    sarIn  = {opnd, {DATA_W{1'b0}}};
    sarExt = sarIn >>> st.amount;

    dpo = '0;
    res = opnd;
    if (st.selRol) begin
      res       = rolExt[EXT_W-1:DATA_W];
      dpo.carry = res[0];
      dpo.over  = res[0] ^ res[DATA_W-1];
    end else if (st.selRor) begin
      res       = rorExt[DATA_W-1:0];
      dpo.carry = res[DATA_W-1];
      dpo.over  = res[DATA_W-1] ^ res[DATA_W-2];
    end else if (st.selShl) begin
      res       = shlExt[DATA_W-1:0];
      dpo.carry = shlExt[DATA_W];
      dpo.over  = shlExt[DATA_W] ^ res[DATA_W-1];
    end else if (st.selShr) begin
      res       = shrExt[EXT_W-1:DATA_W];
      dpo.carry = shrExt[DATA_W-1];
      dpo.over  = res[DATA_W-1] ^ res[DATA_W-2];
    end else if (st.selSar) begin
      res       = sarExt[EXT_W-1:DATA_W];
      dpo.carry = sarExt[DATA_W-1];
      dpo.over  = 1'b0;
    end
    dpo.result = res;
    dpo.sign   = res[DATA_W-1];
    dpo.zero   = ~|res;
    dpo.parity = ~^res[7:0];
  end
endmodule

// File: rtl/rotshift16.sv
`timescale 1ns/1ps
module rotshift16
  import rotshift16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   inOp,
  input  logic [CNT_W-1:0]  inCount,
  input  logic [DATA_W-1:0] inOperand,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult,
  output logic [FLAG_N-1:0] outFlagMask,
  output logic              outCarry,
  output logic              outOverflow,
  output logic              outSign,
  output logic              outZero,
  output logic              outParity
);
  strobes_t          strobes;
  dpOut_t            dpo;
  logic [FLAG_N-1:0] flagVals;
  logic [FLAG_N-1:0] flagsGated;

  rotshift16_ctrl uCtrl (
    .op      (inOp),
    .count   (inCount),
    .strobes (strobes)
  );

  rotshift16_dp uDp (
    .st   (strobes),
    .opnd (inOperand),
    .dpo  (dpo)
  );

  always_comb begin
    flagVals           = '0;
    flagVals[FL_CARRY] = dpo.carry;
    flagVals[FL_OVER]  = dpo.over;
    flagVals[FL_SIGN]  = dpo.sign;
    flagVals[FL_ZERO]  = dpo.zero;
    flagVals[FL_PAR]   = dpo.parity;
    flagsGated         = flagVals & strobes.flagMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outResult   <= '0;
      outFlagMask <= '0;
      outCarry    <= 1'b0;
      outOverflow <= 1'b0;
      outSign     <= 1'b0;
      outZero     <= 1'b0;
      outParity   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outResult   <= (strobes.flagMask == '0) ? inOperand : dpo.result;
        outFlagMask <= strobes.flagMask;
        outCarry    <= flagsGated[FL_CARRY];
        outOverflow <= flagsGated[FL_OVER];
        outSign     <= flagsGated[FL_SIGN];
        outZero     <= flagsGated[FL_ZERO];
        outParity   <= flagsGated[FL_PAR];
      end
    end
  end
endmodule

// File: rtl/rotshift16_checker.sv
`timescale 1ns/1ps
module rotshift16_checker
  import rotshift16_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OP_W-1:0]   inOp,
  input logic [CNT_W-1:0]  inCount,
  input logic [DATA_W-1:0] inOperand,
  input logic              outValid,
  input logic [DATA_W-1:0] outResult,
  input logic [FLAG_N-1:0] outFlagMask,
  input logic              outCarry,
  input logic              outOverflow,
  input logic              outSign,
  input logic              outZero,
  input logic              outParity
);
  logic [FLAG_N-1:0] seenFlags;
  assign seenFlags = {outParity, outZero, outSign, outOverflow, outCarry};

  a_r2_valid_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  a_r12_unmasked_flags_low: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((seenFlags & ~outFlagMask) == '0));

  a_r3_unused_code_passes: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && ($past(inOp) > OP_SAR)) |->
      (outFlagMask == '0 && outResult == $past(inOperand)));

  a_r6_rotate_bit4_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && ($past(inOp) <= OP_ROR) && ($past(inCount[ROT_W-1:0]) == '0)) |->
      (outResult == $past(inOperand)));

  a_r7_zero_shift_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && ($past(inOp) >= OP_SHL) && ($past(inOp) <= OP_SAR) &&
     ($past(inCount[SH_W-1:0]) == '0)) |->
      (outFlagMask == '0 && outResult == $past(inOperand)));

  a_r8_left_past_width: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && ($past(inOp) == OP_SHL) && ($past(inCount[SH_W-1:0]) > DATA_W)) |->
      (outResult == '0 && !outCarry && !outOverflow));

  a_r10_arith_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && ($past(inOp) == OP_SAR)) |-> !outOverflow);
endmodule

bind rotshift16 rotshift16_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inOp        (inOp),
  .inCount     (inCount),
  .inOperand   (inOperand),
  .outValid    (outValid),
  .outResult   (outResult),
  .outFlagMask (outFlagMask),
  .outCarry    (outCarry),
  .outOverflow (outOverflow),
  .outSign     (outSign),
  .outZero     (outZero),
  .outParity   (outParity)
);

// File: tb/rotshift16_test.sv
`timescale 1ns/1ps
module rotshift16_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  inOp = '0;
  logic [7:0]  inCount = '0;
  logic [15:0] inOperand = '0;
  logic        outValid;
  logic [15:0] outResult;
  logic [4:0]  outFlagMask;
  logic        outCarry, outOverflow, outSign, outZero, outParity;

  always #4 clk = ~clk;

  rotshift16 uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inCount(inCount),
    .inOperand(inOperand), .outValid(outValid), .outResult(outResult),
    .outFlagMask(outFlagMask), .outCarry(outCarry), .outOverflow(outOverflow),
    .outSign(outSign), .outZero(outZero), .outParity(outParity)
  );

  typedef struct packed {
    logic        vld;
    logic [15:0] res;
    logic [4:0]  mask;
    logic [4:0]  flags; // {parity, zero, sign, overflow, carry}
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    nTests = 0;
  int    nFail = 0;
  logic  monOn = 1'b0;
  logic  finished = 1'b0;

  function automatic exp_t refModel(logic [2:0] op, logic [7:0] cnt, logic [15:0] x);
    exp_t e;
    logic [15:0] r;
    logic c, o;
    int n;
    e = '0; e.vld = 1'b1; r = x; c = 1'b0; o = 1'b0;
    if (op == 3'd0 || op == 3'd1) begin
      if (cnt[4:0] != 5'd0) begin
        n = int'(cnt[3:0]);
        for (int i = 0; i < n; i++) r = (op == 3'd0) ? {r[14:0], r[15]} : {r[0], r[15:1]};
        if (op == 3'd0) begin c = r[0]; o = r[0] ^ r[15]; end
        else begin c = r[15]; o = r[15] ^ r[14]; end
        e.mask = 5'b00011;
        e.flags = {3'b000, o, c};
      end
    end else if (op >= 3'd2 && op <= 3'd4) begin
      n = int'(cnt[4:0]);
      if (n != 0) begin
        for (int i = 0; i < n; i++) begin
          if (op == 3'd2) begin c = r[15]; r = {r[14:0], 1'b0}; end
          else if (op == 3'd3) begin c = r[0]; r = {1'b0, r[15:1]}; end
          else begin c = r[0]; r = {r[15], r[15:1]}; end
        end
        if (op == 3'd2) o = c ^ r[15];
        else if (op == 3'd3) o = r[15] ^ r[14];
        else o = 1'b0;
        e.mask = 5'b11111;
        e.flags = {~^r[7:0], (r == 16'd0), r[15], o, c};
      end
    end
    e.res = r;
    return e;
  endfunction

  function automatic string tagFor(logic [2:0] op, logic [7:0] cnt);
    case (op)
      3'd0: return (cnt[3:0] == 4'd0) ? "R6" : "R4";
      3'd1: return (cnt[3:0] == 4'd0) ? "R6" : "R5";
      3'd2: return (cnt[4:0] == 5'd0) ? "R7" : "R8";
      3'd3: return (cnt[4:0] == 5'd0) ? "R7" : "R9";
      3'd4: return (cnt[4:0] == 5'd0) ? "R7" : "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic drive(input logic [2:0] op, input logic [7:0] cnt, input logic [15:0] x);
    @(negedge clk);
    inValid = 1'b1; inOp = op; inCount = cnt; inOperand = x;
    expQ.push_back(refModel(op, cnt, x));
    tagQ.push_back(tagFor(op, cnt));
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; inOp = 3'($urandom_range(0, 7)); inCount = 8'($urandom); inOperand = 16'($urandom);
    expQ.push_back('0);
    tagQ.push_back("R2");
  endtask

  task automatic checkOne(input string tag, input logic [31:0] act, input logic [31:0] want);
    nTests++;
    if (act !== want) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, want);
    end
  endtask

  // Monitor: one expectation per cycle, sampled 2 ns after the rising edge.
  always @(posedge clk) begin
    if (monOn && expQ.size() > 0) begin
      exp_t  e;
      string t;
      #2;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      if (!e.vld) begin
        checkOne("R2", {31'd0, outValid}, 32'd0);
      end else begin
        checkOne("R2", {31'd0, outValid}, 32'd1);
        checkOne(t, {16'd0, outResult}, {16'd0, e.res});
        checkOne({t, "/R11"}, {27'd0, outFlagMask}, {27'd0, e.mask});
        checkOne({t, "/R12"}, {27'd0, outParity, outZero, outSign, outOverflow, outCarry},
                 {27'd0, e.flags});
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    checkOne("R1", {9'd0, outValid, outResult, outFlagMask, outCarry},
             32'd0);
    checkOne("R1", {28'd0, outOverflow, outSign, outZero, outParity}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;

    // Rotates, R4/R5/R6
    drive(3'd0, 8'd1,    16'h8001);
    drive(3'd0, 8'd4,    16'h1234);
    drive(3'd0, 8'h10,   16'h8001);
    drive(3'd0, 8'h10,   16'h4000);
    drive(3'd0, 8'h20,   16'h8001);
    drive(3'd0, 8'hE0,   16'h5A5A);
    drive(3'd0, 8'h13,   16'hF00F);
    drive(3'd1, 8'd1,    16'h0001);
    drive(3'd1, 8'd15,   16'h1234);
    drive(3'd1, 8'h10,   16'h4000);
    drive(3'd1, 8'h00,   16'hBEEF);
    idle();
    // Shift left, R8/R11
    drive(3'd2, 8'd1,    16'hC000);
    drive(3'd2, 8'd16,   16'h0001);
    drive(3'd2, 8'd17,   16'hFFFF);
    drive(3'd2, 8'd31,   16'hFFFF);
    drive(3'd2, 8'h20,   16'h1234);
    drive(3'd2, 8'd3,    16'h0101);
    // Logical right, R9
    drive(3'd3, 8'd1,    16'h8001);
    drive(3'd3, 8'd16,   16'h8000);
    drive(3'd3, 8'd17,   16'hFFFF);
    drive(3'd3, 8'd5,    16'h00F0);
    // Arithmetic right, R10
    drive(3'd4, 8'd1,    16'h8001);
    drive(3'd4, 8'd15,   16'h8000);
    drive(3'd4, 8'd16,   16'h8000);
    drive(3'd4, 8'd31,   16'h8000);
    drive(3'd4, 8'd20,   16'h7FFF);
    drive(3'd4, 8'd0,    16'h8000);
    idle();
    idle();
    // Unused codes, R3
    drive(3'd5, 8'd3,    16'hCAFE);
    drive(3'd6, 8'd1,    16'h0F0F);
    drive(3'd7, 8'd9,    16'h0000);
    // Pseudo-random stream with idle gaps
    for (int k = 0; k < 600; k++) begin
      logic [2:0] op;
      logic [7:0] cnt;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op  = 3'($urandom_range(0, 7));
      cnt = 8'($urandom);
      if (lfsr[3:0] == 4'd0) idle();
      else drive(op, cnt, lfsr ^ 16'($urandom));
    end
    idle();
    idle();
    @(posedge clk);
    #3;
    monOn = 1'b0;
    if (expQ.size() != 0) begin
      nTests++; nFail++;
      $display("FAIL R2 pending actual=%0d expected=0", expQ.size());
    end
    finish();
  end
endmodule